// File: doc/BRIEF.md
# Bit-Order-Selectable Serial Shift Engine

This block moves bytes between a parallel host side and a pair of serial lines. The host offers transmit bytes on a valid/ready stream. The engine copies each accepted byte into a private shift register and clocks it out on `sdo` under a serial clock that it generates from the system clock. While it sends, it captures the same number of bits from `sdi`. A transfer is one, two or four bytes long, as set by a size code. Each byte that completes lands in the next slot of a four-byte receive bank.

Bit order is chosen per transfer, either least-significant bit first or most-significant bit first. The shift register always sends from its bit 0. When the order is MSB-first, the transmit byte is reversed as it is loaded and the captured byte is reversed as it is stored. The size code and the bit order are both latched when the first byte of a transfer is accepted.

Back-pressure works as follows. `tx_ready` is high only when the engine can take a byte: while idle with a legal size code, or between the bytes of a multi-byte transfer. A byte moves on any rising `clk` edge where `tx_valid` and `tx_ready` are both high. While `tx_valid` is low between bytes, the engine waits with the serial clock parked low. `tx_data` must stay stable while `tx_valid` is high and `tx_ready` is low.

Top module: `serial_shift_engine`

## Requirements
- R1: With order bit `cfg_msb_first`=0, `sdo` presents transmit bit 0 from the cycle after the byte is accepted. It then presents bits 1 to 7 in turn, changing only when `sclk` falls, and is 0 once all eight bits are sent.
- R2: With `cfg_msb_first`=1, `sdo` presents transmit bit 7 first and bit 0 last, with the same timing as R1.
- R3: `sdi` is sampled on each rising `sclk`. With LSB-first order, the first sampled bit becomes bit 0 of the stored byte.
- R4: With MSB-first order, the first sampled bit becomes bit 7 of the stored byte.
- R5: `sclk` is low at rest. While a byte shifts, each `sclk` level lasts DIV_HALF clock cycles, with exactly eight high pulses per byte. `sclk` stays low between bytes.
- R6: Size code 00 moves one byte and sets `rx_valid`=0001. Code 01 moves two bytes and sets 0011. Code 10 moves four bytes and sets 1111. Byte k of a transfer is stored in `rx_word[8k+7:8k]`.
- R7: `rx_full` clears when a transfer starts and rises on the same edge that stores the transfer's last byte.
- R8: Size code 11 holds `tx_ready` low while idle. A `tx_valid` seen then sets `cfg_err`, clears `rx_valid` and `rx_full`, and starts nothing. `cfg_err` clears when a legal transfer starts.
- R9: Between bytes of a transfer, `tx_ready` is high and the engine holds until `tx_valid`. While a byte is shifting, `tx_ready` is low and an offered byte is held off.
- R10: `busy` is high from the cycle after the first byte is accepted until the edge that stores the last byte.
- R11: Changes to `cfg_msb_first` or `cfg_size` after a transfer starts do not affect that transfer.
- R12: After reset, `sclk`, `sdo`, `busy`, `rx_word`, `rx_valid`, `rx_full` and `cfg_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_msb_first | input | 1 | Bit order: 0 LSB first, 1 MSB first |
| cfg_size | input | 2 | Transfer size code (00 one byte, 01 two, 10 four, 11 illegal) |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Engine can accept a transmit byte |
| tx_data | input | 8 | Transmit byte |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| busy | output | 1 | Transfer in progress |
| rx_word | output | 32 | Receive bank, byte k in bits 8k+7:8k |
| rx_valid | output | 4 | Which receive bytes belong to the last transfer |
| rx_full | output | 1 | Last transfer's final byte has been stored |
| cfg_err | output | 1 | Illegal size code was requested |

## Verification
The bench goes after the reversal on both paths. An engine that reversed only the transmit side would send correct MSB-first data but store captured bytes backwards.

It also covers these cases:
- **Long gaps between bytes.** A design that let `sclk` run while waiting would lose or duplicate bits.
- **Flipping the configuration in the middle of a transfer.** A design that read the live pins would switch order or length in mid-stream.
- **An attempt with size code 11 followed by a legal transfer.** This catches a latched error that never clears, or a transfer that starts on an illegal code.

Random `sdi` data makes each stored byte distinct, so a slot-index slip shows up in `rx_word`.

// File: rtl/sse_pkg.sv
package sse_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_WAIT} sse_state_e;

  localparam int BYTE_W = 8;
  localparam int SLOTS = 4;
  localparam int IDX_W = $clog2(SLOTS);
  localparam logic [1:0] SIZE_BAD = 2'b11;

  function automatic logic [BYTE_W-1:0] bit_rev(input logic [BYTE_W-1:0] d);
    logic [BYTE_W-1:0] r;
    for (int i = 0; i < BYTE_W; i++) r[i] = d[BYTE_W-1-i];
    return r;
  endfunction

  function automatic logic [SLOTS-1:0] size_mask(input logic [1:0] s);
    case (s)
      2'b00: return 4'b0001;
      2'b01: return 4'b0011;
      2'b10: return 4'b1111;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic [IDX_W-1:0] size_last(input logic [1:0] s);
    case (s)
      2'b00: return 2'd0;
      2'b01: return 2'd1;
      default: return 2'd3;
    endcase
  endfunction
endpackage

// File: rtl/sse_sclk_gen.sv
module sse_sclk_gen #(
  parameter int DIV_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

  logic [CW-1:0] cnt;
  logic tick;

  assign tick      = run && (cnt == CW'(DIV_HALF - 1));
  assign rise_tick = tick && !sclk;
  assign fall_tick = tick && sclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (!run) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (tick) begin
      cnt  <= '0;
      sclk <= ~sclk;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R5: serial clock parks low whenever shifting stops
  assert_sclk_park_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !sclk);
endmodule

// File: rtl/sse_tx_shifter.sv
module sse_tx_shifter
  import sse_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              msb_first,
  input  logic [BYTE_W-1:0] din,
  input  logic              shift,
  output logic              sdo
);
  logic [BYTE_W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh <= '0;
    else if (load)  sh <= msb_first ? bit_rev(din) : din;
    else if (shift) sh <= {1'b0, sh[BYTE_W-1:1]};
  end

  assign sdo = sh[0];

  // R1: output bit moves only on a load or a falling serial edge
  assert_sdo_steady_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !shift) |=> $stable(sdo));
endmodule

// File: rtl/sse_rx_bank.sv
module sse_rx_bank
  import sse_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sample,
  input  logic                    sdi,
  input  logic                    store,
  input  logic                    msb_first,
  input  logic [IDX_W-1:0]        idx,
  output logic [SLOTS*BYTE_W-1:0] rx_word
);
  logic [BYTE_W-1:0] cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cap <= '0;
    else if (sample) cap <= {sdi, cap[BYTE_W-1:1]};
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic [BYTE_W-1:0] slot;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              slot <= '0;
      else if (store && idx == IDX_W'(g))      slot <= msb_first ? bit_rev(cap) : cap;
    end
    assign rx_word[g*BYTE_W +: BYTE_W] = slot;
  end

  // R3: a byte is never stored on the same edge a bit is captured
  assert_store_apart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    store |-> !sample);
endmodule

// File: rtl/serial_shift_engine.sv
module serial_shift_engine
  import sse_pkg::*;
#(
  parameter int DIV_HALF = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_msb_first,
  input  logic [1:0]  cfg_size,
  input  logic        tx_valid,
  output logic        tx_ready,
  input  logic [7:0]  tx_data,
  output logic        sclk,
  output logic        sdo,
  input  logic        sdi,
  output logic        busy,
  output logic [31:0] rx_word,
  output logic [3:0]  rx_valid,
  output logic        rx_full,
  output logic        cfg_err
);
  sse_state_e       state;
  logic [2:0]       bit_cnt;
  logic [IDX_W-1:0] byte_idx;
  logic             msb_q;
  logic [1:0]       size_q;
  logic             rise_tick, fall_tick;
  logic             accept, reject, byte_done, last, load_msb;

  assign tx_ready  = (state == ST_WAIT) || (state == ST_IDLE && cfg_size != SIZE_BAD);
  assign accept    = tx_valid && tx_ready;
  assign reject    = (state == ST_IDLE) && tx_valid && (cfg_size == SIZE_BAD);
  assign byte_done = fall_tick && (bit_cnt == 3'd7);
  assign last      = (byte_idx == size_last(size_q));
  assign load_msb  = (state == ST_IDLE) ? cfg_msb_first : msb_q;
  assign busy      = (state != ST_IDLE);

  sse_sclk_gen #(.DIV_HALF(DIV_HALF)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(state == ST_SHIFT),
    .sclk(sclk), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  sse_tx_shifter u_tx (
    .clk(clk), .rst_n(rst_n), .load(accept), .msb_first(load_msb),
    .din(tx_data), .shift(fall_tick), .sdo(sdo)
  );

  sse_rx_bank u_rx (
    .clk(clk), .rst_n(rst_n), .sample(rise_tick), .sdi(sdi),
    .store(byte_done), .msb_first(msb_q), .idx(byte_idx), .rx_word(rx_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      byte_idx <= '0;
      msb_q    <= 1'b0;
      size_q   <= 2'b00;
      rx_valid <= '0;
      rx_full  <= 1'b0;
      cfg_err  <= 1'b0;
    end else if (reject) begin
      cfg_err  <= 1'b1;
      rx_valid <= '0;
      rx_full  <= 1'b0;
    end else if (accept) begin
      if (state == ST_IDLE) begin
        msb_q    <= cfg_msb_first;
        size_q   <= cfg_size;
        byte_idx <= '0;
        cfg_err  <= 1'b0;
        rx_full  <= 1'b0;
        rx_valid <= size_mask(cfg_size);
      end
      state   <= ST_SHIFT;
      bit_cnt <= '0;
    end else if (state == ST_SHIFT && fall_tick) begin
      bit_cnt <= bit_cnt + 1'b1;
      if (byte_done) begin
        if (last) begin
          state   <= ST_IDLE;
          rx_full <= 1'b1;
        end else begin
          state    <= ST_WAIT;
          byte_idx <= byte_idx + 1'b1;
        end
      end
    end
  end

  // R8: illegal size code blocks the stream and flags an error
  assert_bad_size_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && cfg_size == SIZE_BAD) |-> !tx_ready);
  assert_reject_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> (cfg_err && rx_valid == 4'b0000 && !busy));
  // R7: full flag follows the store of the final byte
  assert_full_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && last) |=> (rx_full && !busy));
  // R10: accepted byte makes the engine busy
  assert_accept_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
  // R5: no serial clock outside active shifting
  assert_sclk_only_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_SHIFT) |-> !sclk);
  // R6: valid mask takes only the shapes of the size codes
  assert_mask_shape_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid inside {4'b0000, 4'b0001, 4'b0011, 4'b1111});
  // R11: latched configuration holds while shifting
  assert_cfg_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SHIFT) |=> ($stable(size_q) && $stable(msb_q)));
endmodule

// File: tb/serial_shift_engine_test.sv
module serial_shift_engine_test;
  localparam int DIV_HALF = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_msb_first = 1'b0;
  logic [1:0]  cfg_size = 2'b00;
  logic        tx_valid = 1'b0;
  logic [7:0]  tx_data = 8'h00;
  logic        sdi = 1'b0;
  logic        tx_ready, sclk, sdo, busy, rx_full, cfg_err;
  logic [31:0] rx_word;
  logic [3:0]  rx_valid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  serial_shift_engine #(.DIV_HALF(DIV_HALF)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_msb_first(cfg_msb_first), .cfg_size(cfg_size),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .sclk(sclk), .sdo(sdo), .sdi(sdi), .busy(busy), .rx_word(rx_word),
    .rx_valid(rx_valid), .rx_full(rx_full), .cfg_err(cfg_err)
  );

  // behavioural reference: 0 idle, 1 shifting, 2 waiting for next byte
  int         m_state, m_cnt, m_sent, m_got, m_idx;
  bit         m_sclk, m_msb, m_full, m_err;
  logic [1:0] m_size;
  logic [7:0] m_byte, m_rxb;
  logic [7:0] m_rx [4];
  logic [3:0] m_valid;

  function automatic int last_of(input logic [1:0] s);
    return (s == 2'b00) ? 0 : (s == 2'b01) ? 1 : 3;
  endfunction

  function automatic logic [3:0] mask_of(input logic [1:0] s);
    return (s == 2'b00) ? 4'b0001 : (s == 2'b01) ? 4'b0011 : (s == 2'b10) ? 4'b1111 : 4'b0000;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_cnt = 0; m_sent = 8; m_got = 0; m_idx = 0;
      m_sclk = 0; m_msb = 0; m_full = 0; m_err = 0; m_size = 2'b00;
      m_byte = 8'h00; m_rxb = 8'h00; m_valid = 4'b0000;
      for (int i = 0; i < 4; i++) m_rx[i] = 8'h00;
    end else if (m_state == 0 && tx_valid && cfg_size == 2'b11) begin
      m_err = 1; m_valid = 4'b0000; m_full = 0;
    end else if (tx_valid && (m_state == 2 || (m_state == 0 && cfg_size != 2'b11))) begin
      if (m_state == 0) begin
        m_msb = cfg_msb_first; m_size = cfg_size; m_idx = 0;
        m_err = 0; m_full = 0; m_valid = mask_of(cfg_size);
      end
      m_byte = tx_data; m_sent = 0; m_got = 0; m_rxb = 8'h00;
      m_cnt = 0; m_sclk = 0; m_state = 1;
    end else if (m_state == 1) begin
      if (m_cnt == DIV_HALF - 1) begin
        m_cnt = 0;
        if (!m_sclk) begin
          m_rxb[m_msb ? 7 - m_got : m_got] = sdi;
          m_got++;
          m_sclk = 1;
        end else begin
          m_sclk = 0;
          m_sent++;
          if (m_sent == 8) begin
            m_rx[m_idx] = m_rxb;
            if (m_idx == last_of(m_size)) begin m_full = 1; m_state = 0; end
            else begin m_idx++; m_state = 2; end
          end
        end
      end else m_cnt++;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic e_sdo;
      e_sdo = (m_sent < 8) ? (m_msb ? m_byte[7 - m_sent] : m_byte[m_sent]) : 1'b0;
      chk("R5", "sclk", 32'(sclk), 32'(m_sclk));
      chk(m_msb ? "R2" : "R1", "sdo", 32'(sdo), 32'(e_sdo));
      chk("R10", "busy", 32'(busy), 32'(m_state != 0));
      chk("R9", "tx_ready", 32'(tx_ready), 32'(m_state == 2 || (m_state == 0 && cfg_size != 2'b11)));
      chk("R7", "rx_full", 32'(rx_full), 32'(m_full));
      chk("R8", "cfg_err", 32'(cfg_err), 32'(m_err));
      chk("R6", "rx_valid", 32'(rx_valid), 32'(m_valid));
      chk("R3,R4,R6", "rx_word", rx_word, {m_rx[3], m_rx[2], m_rx[1], m_rx[0]});
    end
  end

  // random serial input, changed away from the clock edge
  initial begin
    forever begin
      @(posedge clk); #2;
      sdi = 1'($urandom);
    end
  end

  task automatic push(input logic [7:0] d);
    bit got;
    tx_valid = 1'b1; tx_data = d;
    forever begin
      @(negedge clk); got = tx_ready;
      @(posedge clk); #2;
      if (got) break;
    end
    tx_valid = 1'b0;
  endtask

  task automatic wait_idle();
    bit b;
    forever begin
      @(negedge clk); b = busy;
      @(posedge clk); #2;
      if (!b) break;
    end
  endtask

  task automatic xfer(input bit msb, input logic [1:0] size, input int n, input int gap, input logic [7:0] base);
    cfg_msb_first = msb; cfg_size = size;
    for (int i = 0; i < n; i++) begin
      push(base + 8'(i * 8'h35));
      repeat (gap) begin @(posedge clk); #2; end
    end
    wait_idle();
  endtask

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R12: reset values
    chk("R12", "sclk", 32'(sclk), 0);
    chk("R12", "sdo", 32'(sdo), 0);
    chk("R12", "busy", 32'(busy), 0);
    chk("R12", "rx_word", rx_word, 0);
    chk("R12", "rx_valid", 32'(rx_valid), 0);
    chk("R12", "rx_full", 32'(rx_full), 0);
    chk("R12", "cfg_err", 32'(cfg_err), 0);
    @(posedge clk); #2; rst_n = 1'b1;

    xfer(1'b0, 2'b00, 1, 0, 8'hA5);   // R1 R3 single byte LSB-first
    xfer(1'b1, 2'b00, 1, 0, 8'h3C);   // R2 R4 single byte MSB-first
    xfer(1'b0, 2'b01, 2, 5, 8'h81);   // R6 R9 two bytes, gap between them
    xfer(1'b1, 2'b10, 4, 0, 8'h17);   // R6 four bytes, next byte held off
    xfer(1'b0, 2'b10, 4, 9, 8'hF0);   // R9 long waits between bytes

    // R8: illegal code, held offer, then recovery
    cfg_size = 2'b11; tx_valid = 1'b1; tx_data = 8'h55;
    repeat (4) begin @(posedge clk); #2; end
    tx_valid = 1'b0;
    repeat (3) begin @(posedge clk); #2; end
    xfer(1'b1, 2'b01, 2, 1, 8'h6E);

    // R11: configuration flipped after the start
    cfg_msb_first = 1'b1; cfg_size = 2'b01;
    push(8'hC3);
    cfg_msb_first = 1'b0; cfg_size = 2'b10;
    repeat (3) begin @(posedge clk); #2; end
    push(8'h29);
    wait_idle();
    cfg_size = 2'b11;
    repeat (2) begin @(posedge clk); #2; end
    cfg_size = 2'b00;
    xfer(1'b1, 2'b00, 1, 0, 8'h01);

    repeat (4) @(posedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL R9 watchdog actual=stalled expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule